// File: doc/BRIEF.md
# GPIO Port Pad Controller

This block holds the per-pin configuration of an 8-bit general-purpose I/O port and turns it into the control signals for each pad. Four configuration registers sit behind a small synchronous register bus: the port latch, a digital/analog input-mode register, an open-drain/push-pull output-mode register and a skip register. The skip register is only stored and read back. The crossbar that hands pins to peripherals lives elsewhere. That crossbar uses the skip register, and it gives this block its decision for each pin as already-decoded inputs: a pin-assigned flag, the peripheral's output value and output enable, and a flag that marks the pin as a two-wire bus line.

From these inputs and from two global controls (crossbar enable and weak-pullup disable), the block computes four pad signals for every pin: driver enable, drive value, weak-pullup enable and receiver enable. It also passes the pad input value through a synchroniser and returns it, masked to 0 on analog pins. All pad controls are combinational from the registers and inputs. The only latency is the register write and the input synchroniser.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset, reads return latch = 0xFF (address 0), input mode = 0xFF (address 1), output mode = 0x00 (address 2) and skip = 0x00 (address 3).
- R2: A write with `reg_we` high stores `reg_wdata` into the register selected by `reg_addr` (0 latch, 1 input mode, 2 output mode, 3 skip). The new value is readable and takes effect from the clock edge of the write onward.
- R3: A pin whose input-mode bit is 0 (analog) has driver enable, weak-pullup enable and receiver enable all at 0. A pin whose input-mode bit is 1 has its receiver enabled.
- R4: While `xbar_en` is 0, every `pad_oe` bit is 0, whatever the peripheral inputs are.
- R5: A pin with `periph_sel` at 0 uses its latch bit as the drive value.
- R6: A pin with `periph_sel` at 1 uses `periph_out` as the drive value, and its driver can be enabled only while `periph_oe` is 1.
- R7: With the driver otherwise allowed, an open-drain pin (output-mode bit 0) enables its driver only for drive value 0. A push-pull pin (output-mode bit 1) enables its driver for both values.
- R8: A pin with `twowire_pin` at 1 behaves as open-drain whatever its output-mode bit is.
- R9: The weak pullup is on exactly when the pin is digital, acts as open-drain, `wpu_dis` is 0, and the pin is not actively driving 0. Push-pull pins never have the pullup.
- R10: `pin_in` shows `pad_in` two clock edges after the pad changes. It does not show it after one edge. Analog pins read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| xbar_en | input | 1 | Global crossbar enable; 0 disables all drivers |
| wpu_dis | input | 1 | Global weak-pullup disable |
| periph_sel | input | 8 | Pin is assigned to a peripheral |
| periph_out | input | 8 | Peripheral output value |
| periph_oe | input | 8 | Peripheral output enable |
| twowire_pin | input | 8 | Pin is a two-wire bus line (forced open-drain) |
| pad_in | input | 8 | Raw pad input value |
| pad_oe | output | 8 | Pad driver enable |
| pad_out | output | 8 | Pad drive value |
| pad_pu_en | output | 8 | Weak-pullup enable |
| pad_rx_en | output | 8 | Digital receiver enable |
| pin_in | output | 8 | Synchronised, analog-masked input value |

## Verification
The pad controls carry no register of their own. They settle within the same cycle as the global and peripheral inputs change, and within the cycle after the write edge when a register changes. The bench therefore writes the registers, then sets the inputs, and compares outputs at the next falling edge. The synchronised input is due on the second rising edge after `pad_in` changes. The bench checks it at the falling edge after the first rising edge, where it must still hold the old value, and again after the second, where it must hold the new value.

// File: rtl/gpio_pad_pkg.sv
// Shared definitions for the GPIO pad controller.
// Assumes four configuration registers selected by a 2-bit address.
package gpio_pad_pkg;
    typedef enum logic [1:0] {
        SEL_LATCH   = 2'd0,
        SEL_INMODE  = 2'd1,
        SEL_OUTMODE = 2'd2,
        SEL_SKIP    = 2'd3
    } cfg_sel_e;

    localparam int CFG_ADDR_W = 2;

    // Per-pin resolved pad control bundle
    typedef struct packed {
        logic oe;
        logic val;
        logic pu;
        logic rx;
    } pad_ctl_t;
endpackage

// File: rtl/gpio_cfg_regs.sv
// Configuration register bank: latch, input mode, output mode, skip.
// Assumes a single-cycle write strobe and a combinational read path.
module gpio_cfg_regs
    import gpio_pad_pkg::*;
#(
    parameter int         WIDTH       = 8,
    parameter logic [7:0] LATCH_RST   = 8'hFF,
    parameter logic [7:0] INMODE_RST  = 8'hFF,
    parameter logic [7:0] OUTMODE_RST = 8'h00,
    parameter logic [7:0] SKIP_RST    = 8'h00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [CFG_ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]      wdata,
    output logic [WIDTH-1:0]      rdata,
    output logic [WIDTH-1:0]      latch_q,
    output logic [WIDTH-1:0]      inmode_q,
    output logic [WIDTH-1:0]      outmode_q,
    output logic [WIDTH-1:0]      skip_q
);
    cfg_sel_e sel;
    assign sel = cfg_sel_e'(addr);

    // Register update: reset to defaults, else store the addressed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q   <= WIDTH'(LATCH_RST);
            inmode_q  <= WIDTH'(INMODE_RST);
            outmode_q <= WIDTH'(OUTMODE_RST);
            skip_q    <= WIDTH'(SKIP_RST);
        end else if (we) begin
            case (sel)
                SEL_LATCH:   latch_q   <= wdata;
                SEL_INMODE:  inmode_q  <= wdata;
                SEL_OUTMODE: outmode_q <= wdata;
                default:     skip_q    <= wdata;
            endcase
        end
    end

    // Read mux: return the addressed register
    always_comb begin
        case (sel)
            SEL_LATCH:   rdata = latch_q;
            SEL_INMODE:  rdata = inmode_q;
            SEL_OUTMODE: rdata = outmode_q;
            default:     rdata = skip_q;
        endcase
    end

    // R2
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_LATCH) |=> latch_q == $past(wdata));

    // R2
    inmode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == SEL_INMODE) |=> $stable(inmode_q));
endmodule

// File: rtl/gpio_pin_ctl.sv
// Per-pin pad control: resolves driver, drive value, pullup and receiver
// from mode bits, global controls and the peripheral override.
// Assumes the crossbar has already decided the peripheral assignment.
module gpio_pin_ctl
    import gpio_pad_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     digital,
    input  logic     push_pull,
    input  logic     latch_bit,
    input  logic     xbar_en,
    input  logic     wpu_dis,
    input  logic     psel,
    input  logic     pout,
    input  logic     poe,
    input  logic     twowire,
    output pad_ctl_t ctl
);
    logic open_drain;
    logic value;
    logic drive_ok;

    // Resolve pin behaviour from mode, override and global state
    always_comb begin
        open_drain = twowire | ~push_pull;
        value      = psel ? pout : latch_bit;
        drive_ok   = xbar_en & digital & (psel ? poe : 1'b1);
        ctl.val    = value;
        ctl.oe     = drive_ok & (open_drain ? ~value : 1'b1);
        ctl.pu     = digital & open_drain & ~wpu_dis & ~(drive_ok & ~value);
        ctl.rx     = digital;
    end

    // R3
    analog_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !digital |-> (!ctl.oe && !ctl.pu && !ctl.rx));

    // R4
    xbar_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xbar_en |-> !ctl.oe);

    // R8
    twowire_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (twowire && ctl.oe) |-> !ctl.val);

    // R9
    pp_no_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_pull && !twowire) |-> !ctl.pu);

    // R9
    pullup_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.oe && !ctl.val) |-> !ctl.pu);
endmodule

// File: rtl/gpio_in_sync.sv
// Multi-flop input synchroniser for the pad input vector.
// Assumes the pad input is asynchronous to clk; STAGES >= 2.
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift one synchroniser stage, cleared on reset
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
// Top of the GPIO pad controller: register bank, per-pin control
// replicated per pin, and the input synchroniser with analog masking.
// Assumes peripheral assignment is decoded outside this block.
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [CFG_ADDR_W-1:0] reg_addr,
    input  logic [WIDTH-1:0]      reg_wdata,
    output logic [WIDTH-1:0]      reg_rdata,
    input  logic                  xbar_en,
    input  logic                  wpu_dis,
    input  logic [WIDTH-1:0]      periph_sel,
    input  logic [WIDTH-1:0]      periph_out,
    input  logic [WIDTH-1:0]      periph_oe,
    input  logic [WIDTH-1:0]      twowire_pin,
    input  logic [WIDTH-1:0]      pad_in,
    output logic [WIDTH-1:0]      pad_oe,
    output logic [WIDTH-1:0]      pad_out,
    output logic [WIDTH-1:0]      pad_pu_en,
    output logic [WIDTH-1:0]      pad_rx_en,
    output logic [WIDTH-1:0]      pin_in
);
    logic [WIDTH-1:0] latch_q, inmode_q, outmode_q, skip_q;
    logic [WIDTH-1:0] sync_q;

    gpio_cfg_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .latch_q   (latch_q),
        .inmode_q  (inmode_q),
        .outmode_q (outmode_q),
        .skip_q    (skip_q)
    );

    genvar p;
    generate
        for (p = 0; p < WIDTH; p++) begin : g_pin
            pad_ctl_t ctl;
            gpio_pin_ctl u_pin (
                .clk       (clk),
                .rst_n     (rst_n),
                .digital   (inmode_q[p]),
                .push_pull (outmode_q[p]),
                .latch_bit (latch_q[p]),
                .xbar_en   (xbar_en),
                .wpu_dis   (wpu_dis),
                .psel      (periph_sel[p]),
                .pout      (periph_out[p]),
                .poe       (periph_oe[p]),
                .twowire   (twowire_pin[p]),
                .ctl       (ctl)
            );
            assign pad_oe[p]    = ctl.oe;
            assign pad_out[p]   = ctl.val;
            assign pad_pu_en[p] = ctl.pu;
            assign pad_rx_en[p] = ctl.rx;
        end
    endgenerate

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_q)
    );

    assign pin_in = sync_q & inmode_q;

    // R10
    analog_in_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_in & ~inmode_q) == '0);
endmodule

// File: tb/test_gpio_pad_ctrl.sv
module test_gpio_pad_ctrl;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic xbar_en = 1'b0, wpu_dis = 1'b0;
    logic [W-1:0] periph_sel = '0, periph_out = '0, periph_oe = '0, twowire_pin = '0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_oe, pad_out, pad_pu_en, pad_rx_en, pin_in;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_pad_ctrl i_gpio_pad_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xbar_en(xbar_en),
        .wpu_dis(wpu_dis), .periph_sel(periph_sel), .periph_out(periph_out),
        .periph_oe(periph_oe), .twowire_pin(twowire_pin), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu_en(pad_pu_en),
        .pad_rx_en(pad_rx_en), .pin_in(pin_in)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [W-1:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] lat, inm, outm, e_oe, e_val, e_pu;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        rd("R1 latch", 2'd0, 8'hFF);
        rd("R1 inmode", 2'd1, 8'hFF);
        rd("R1 outmode", 2'd2, 8'h00);
        rd("R1 skip", 2'd3, 8'h00);
        check("R3 rx after reset", pad_rx_en, 8'hFF);
        check("R4 no drive after reset", pad_oe, 8'h00);

        // R2 write/readback on every register
        wr(2'd3, 8'hA5); rd("R2 skip", 2'd3, 8'hA5);
        wr(2'd2, 8'h3C); rd("R2 outmode", 2'd2, 8'h3C);
        wr(2'd0, 8'h12); rd("R2 latch", 2'd0, 8'h12);
        wr(2'd1, 8'hC3); rd("R2 inmode", 2'd1, 8'hC3);
        rd("R2 skip unchanged", 2'd3, 8'hA5);

        // Sweep: each pin gets a different 9-bit combination per step
        for (int c = 0; c < 512; c++) begin
            logic [8:0] pc [W];
            for (int i = 0; i < W; i++) pc[i] = 9'((c + i * 67) % 512);
            for (int i = 0; i < W; i++) begin
                lat[i]  = pc[i][0];
                inm[i]  = pc[i][1];
                outm[i] = pc[i][2];
            end
            wr(2'd0, lat); wr(2'd1, inm); wr(2'd2, outm);
            for (int i = 0; i < W; i++) begin
                twowire_pin[i] = pc[i][3];
                periph_sel[i]  = pc[i][4];
                periph_oe[i]   = pc[i][5];
                periph_out[i]  = pc[i][6];
            end
            xbar_en = pc[0][7];
            wpu_dis = pc[0][8];
            @(negedge clk);
            for (int i = 0; i < W; i++) begin
                logic od, ok;
                od       = twowire_pin[i] | ~outm[i];
                e_val[i] = periph_sel[i] ? periph_out[i] : lat[i];
                ok       = xbar_en & inm[i] & (periph_sel[i] ? periph_oe[i] : 1'b1);
                e_oe[i]  = ok & (od ? ~e_val[i] : 1'b1);
                e_pu[i]  = inm[i] & od & ~wpu_dis & ~(ok & ~e_val[i]);
            end
            // R3 R4 R5 R6 R7 R8 covered by driver enable/value
            check("R7 R4 R6 R8 pad_oe", pad_oe, e_oe);
            check("R5 R6 pad_out", pad_out, e_val);
            check("R9 pad_pu_en", pad_pu_en, e_pu);
            check("R3 pad_rx_en", pad_rx_en, inm);
        end

        // R10 synchroniser latency and analog masking
        wr(2'd1, 8'hFF);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk);
        check("R10 one edge still old", pin_in, 8'h00);
        @(negedge clk);
        check("R10 two edges new", pin_in, 8'h5A);
        wr(2'd1, 8'h0F);
        check("R10 analog reads 0", pin_in, 8'h0A);
        pad_in = 8'hF0;
        repeat (2) @(negedge clk);
        check("R10 analog masked", pin_in, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule